// File: doc/BRIEF.md
# Variable-Length Instruction Steering Unit

This block sits between the byte-aligned fetch path and a row of three instruction decoders. Each time it asks for work it loads one 32-byte fetched line with four per-byte mark vectors: opcode-start, instruction-end, complex-instruction (meaningful on the opcode-start byte) and predicted-taken (meaningful on the end byte). It also loads the entry offset at which execution begins in that line. A shifter extracts a 16-byte window that starts at the entry byte, so position 0 of the window is the first byte of the first instruction.

Each cycle the unit scans forward from its consumed position and hands up to three consecutive instructions, in program order, to its decoder slots. Slot 0 is a full slot and takes any instruction. Slots 1 and 2 are partial slots. They take only simple instructions whose opcode-and-operand part is at most 8 bytes. The first instruction that a partial slot cannot take ends the cycle's dispatch, and it is presented again in slot 0 on the next cycle. A predicted-taken instruction ends the window. An instruction whose end byte lies beyond the window is not dispatched. When nothing more can leave the window, the unit raises its request for the next line.

Top module: `insn_steer`

## Requirements
- R1: While reset is held and in the first cycle after it, no slot is valid and `win_req` is 1.
- R2: A line is captured when `line_load` is high at a clock edge where `win_req` is 1. Window byte j is line byte `line_entry`+j, and window positions past line byte 31 carry no marks. In the next cycle the unit dispatches from window offset 0.
- R3: An instruction starts at the consumed position and ends at the first end-marked byte at or after it. Its opcode part starts at the first start-marked byte in that span. A slot's byte output holds the opcode part from that byte onward, with byte 0 in bits 7:0, and is zero past the end byte. The full slot carries 11 bytes and each partial slot carries 8.
- R4: Slot k is valid only if slot k-1 is valid, and valid slots carry strictly increasing window offsets of consecutive instructions.
- R5: Slot 0 is valid whenever the unit holds a window and an instruction that ends inside the window begins at the consumed position.
- R6: A partial slot takes an instruction only if its complex flag (at the opcode-start byte) is 0 and its opcode part is at most 8 bytes long. The first instruction refused ends dispatch for that cycle.
- R7: After an instruction whose end byte carries the taken flag, no later slot is valid in that cycle and `win_req` is 1.
- R8: `win_req` is 1 in a cycle where no instruction ending inside the window remains after this cycle's dispatch, or where nothing can be dispatched. Only as many slots are valid as there are whole instructions left.
- R9: `line_load` while `win_req` is 0 is ignored: the held window and its dispatch sequence continue unchanged.
- R10: When `win_req` is 0, the next cycle's slot 0 holds the instruction that starts right after the last byte dispatched in this cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_load | input | 1 | Offers a new line (taken only while win_req is 1) |
| line_entry | input | 5 | Byte offset of the first instruction in the line |
| line_bytes | input | 256 | Line bytes, byte i in bits 8i+7:8i |
| line_start | input | 32 | Opcode-start mark per byte |
| line_end | input | 32 | Instruction-end mark per byte |
| line_cplx | input | 32 | Complex flag, read at the opcode-start byte |
| line_taken | input | 32 | Predicted-taken flag, read at the end byte |
| slot_valid | output | 3 | Valid per decoder slot, bit 0 is the full slot |
| slot_off | output | 12 | 4-bit window offset of each slot's first byte |
| full_bytes | output | 88 | Opcode part for the full slot |
| part_bytes | output | 128 | Opcode parts for the partial slots, slot 1 in the low 64 bits |
| win_req | output | 1 | Window consumed; next line requested |

## Verification
The hardest situation to reach is a refusal in a partial slot that coincides with other boundaries. Examples are a complex or 9-byte instruction in slot 2 right behind a taken branch, or right before an instruction that crosses the window end. The bench reaches these by generating whole lines from instruction-length and flag distributions over every entry offset. Dedicated passes use only 1-byte instructions, only complex ones, and opcode lengths of 8 and 9. While a window is busy it also offers junk lines, so that the ignored-load case happens many times within one dispatch sequence.

// File: rtl/steer_pkg.sv
// Shared sizing constants for the instruction steering unit.
// Assumes: window no wider than the line; opcode parts of at most FULL_MAX bytes.
package steer_pkg;
    localparam int LINE_B   = 32;  // fetched line width in bytes
    localparam int WIN_B    = 16;  // steering window width in bytes
    localparam int FULL_MAX = 11;  // bytes carried by the full slot
    localparam int PART_MAX = 8;   // byte limit of a partial slot
    localparam int SLOTS    = 3;   // decoder slots, slot 0 full
endpackage

// File: rtl/steer_window.sv
// Window holder: rotates the loaded line so that the entry byte becomes
// window byte 0, keeps the window marks and the consumed position.
// Assumes: load is already qualified by the request; WIN_B <= LINE_B.
module steer_window #(
    parameter int LINE_B = 32,
    parameter int WIN_B  = 16,
    localparam int EW = $clog2(LINE_B),
    localparam int PW = $clog2(WIN_B + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [EW-1:0]       entry,
    input  logic [LINE_B*8-1:0] line_bytes,
    input  logic [LINE_B-1:0]   line_start,
    input  logic [LINE_B-1:0]   line_end,
    input  logic [LINE_B-1:0]   line_cplx,
    input  logic [LINE_B-1:0]   line_taken,
    input  logic                done,
    input  logic [PW-1:0]       new_ptr,
    output logic                active,
    output logic [PW-1:0]       ptr,
    output logic [WIN_B*8-1:0]  w_bytes,
    output logic [WIN_B-1:0]    w_start,
    output logic [WIN_B-1:0]    w_end,
    output logic [WIN_B-1:0]    w_cplx,
    output logic [WIN_B-1:0]    w_taken
);
    logic [WIN_B*8-1:0] rot_bytes;
    logic [WIN_B-1:0]   rot_start, rot_end, rot_cplx, rot_taken;

    // Rotator: shift the line down to the entry byte; zeros fill past the line end.
    always_comb begin
        rot_bytes = (WIN_B*8)'(line_bytes >> {entry, 3'b000});
        rot_start = WIN_B'(line_start >> entry);
        rot_end   = WIN_B'(line_end >> entry);
        rot_cplx  = WIN_B'(line_cplx >> entry);
        rot_taken = WIN_B'(line_taken >> entry);
    end

    // Window state: capture on load, advance or retire while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            ptr     <= '0;
            w_bytes <= '0;
            w_start <= '0;
            w_end   <= '0;
            w_cplx  <= '0;
            w_taken <= '0;
        end else if (load) begin
            active  <= 1'b1;
            ptr     <= '0;
            w_bytes <= rot_bytes;
            w_start <= rot_start;
            w_end   <= rot_end;
            w_cplx  <= rot_cplx;
            w_taken <= rot_taken;
        end else if (active) begin
            if (done) begin
                active <= 1'b0;
            end else begin
                ptr <= new_ptr;
            end
        end
    end
endmodule

// File: rtl/steer_scan.sv
// Boundary scanner: from a start position, finds the first end mark, the
// opcode start inside that span, and the flags of the instruction found.
// Assumes: marks are well formed; a missing opcode mark means opcode at pos.
module steer_scan #(
    parameter int WIN_B = 16,
    localparam int PW = $clog2(WIN_B + 1)
) (
    input  logic [PW-1:0]    pos,
    input  logic [WIN_B-1:0] w_start,
    input  logic [WIN_B-1:0] w_end,
    input  logic [WIN_B-1:0] w_cplx,
    input  logic [WIN_B-1:0] w_taken,
    output logic             found,
    output logic [PW-1:0]    end_pos,
    output logic [PW-1:0]    opc_pos,
    output logic [PW-1:0]    opc_len,
    output logic             is_cplx,
    output logic             is_taken
);
    // Lowest end mark at or above pos (downward loop keeps the lowest hit).
    always_comb begin
        found    = 1'b0;
        end_pos  = pos;
        is_taken = 1'b0;
        for (int j = WIN_B - 1; j >= 0; j--) begin
            if (w_end[j] && (j >= int'(pos))) begin
                found    = 1'b1;
                end_pos  = PW'(j);
                is_taken = w_taken[j];
            end
        end
    end

    // Lowest opcode-start mark inside [pos, end_pos], with its complex flag.
    always_comb begin
        opc_pos = pos;
        is_cplx = 1'b0;
        for (int j = WIN_B - 1; j >= 0; j--) begin
            if (w_start[j] && (j >= int'(pos)) && (j <= int'(end_pos))) begin
                opc_pos = PW'(j);
                is_cplx = w_cplx[j];
            end
        end
    end

    // Opcode-part length in bytes.
    assign opc_len = end_pos - opc_pos + PW'(1);
endmodule

// File: rtl/steer_extract.sv
// Slot byte extractor: moves the opcode part of one instruction to byte 0
// of a slot bus of NB bytes and clears the bytes past its length.
// Assumes: NB <= WIN_B.
module steer_extract #(
    parameter int WIN_B = 16,
    parameter int NB    = 8,
    localparam int PW = $clog2(WIN_B + 1)
) (
    input  logic [WIN_B*8-1:0] w_bytes,
    input  logic [PW-1:0]      opc_pos,
    input  logic [PW-1:0]      opc_len,
    output logic [NB*8-1:0]    out_bytes
);
    logic [NB*8-1:0] sh;

    // Shift to the opcode start and zero-fill beyond the instruction end.
    always_comb begin
        sh = (NB*8)'(w_bytes >> {opc_pos, 3'b000});
        for (int b = 0; b < NB; b++) begin
            out_bytes[b*8 +: 8] = (PW'(b) < opc_len) ? sh[b*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/insn_steer.sv
// Instruction steering unit top: holds one window, scans a chain of
// instructions from the consumed position, applies slot capability rules,
// and requests the next line when the window cannot yield more.
// Assumes: slot 0 is the only full slot; opcode parts fit FULL_MAX bytes.
module insn_steer #(
    parameter int LINE_B   = steer_pkg::LINE_B,
    parameter int WIN_B    = steer_pkg::WIN_B,
    parameter int FULL_MAX = steer_pkg::FULL_MAX,
    parameter int PART_MAX = steer_pkg::PART_MAX,
    parameter int SLOTS    = steer_pkg::SLOTS,
    localparam int EW = $clog2(LINE_B),
    localparam int PW = $clog2(WIN_B + 1),
    localparam int OW = $clog2(WIN_B)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              line_load,
    input  logic [EW-1:0]                     line_entry,
    input  logic [LINE_B*8-1:0]               line_bytes,
    input  logic [LINE_B-1:0]                 line_start,
    input  logic [LINE_B-1:0]                 line_end,
    input  logic [LINE_B-1:0]                 line_cplx,
    input  logic [LINE_B-1:0]                 line_taken,
    output logic [SLOTS-1:0]                  slot_valid,
    output logic [SLOTS*OW-1:0]               slot_off,
    output logic [FULL_MAX*8-1:0]             full_bytes,
    output logic [(SLOTS-1)*PART_MAX*8-1:0]   part_bytes,
    output logic                              win_req
);
    logic               active, done, more, l_taken, load_q;
    logic [PW-1:0]      ptr, new_ptr;
    logic [WIN_B*8-1:0] w_bytes;
    logic [WIN_B-1:0]   w_start, w_end, w_cplx, w_taken;
    logic [SLOTS-1:0]   acc;

    logic [PW-1:0] pos_a  [SLOTS];
    logic          found_a[SLOTS];
    logic [PW-1:0] end_a  [SLOTS];
    logic [PW-1:0] opc_a  [SLOTS];
    logic [PW-1:0] olen_a [SLOTS];
    logic          cplx_a [SLOTS];
    logic          taken_a[SLOTS];

    // A line is taken only while a new window is requested.
    assign load_q = line_load && win_req;

    steer_window #(.LINE_B(LINE_B), .WIN_B(WIN_B)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_q),
        .entry      (line_entry),
        .line_bytes (line_bytes),
        .line_start (line_start),
        .line_end   (line_end),
        .line_cplx  (line_cplx),
        .line_taken (line_taken),
        .done       (done),
        .new_ptr    (new_ptr),
        .active     (active),
        .ptr        (ptr),
        .w_bytes    (w_bytes),
        .w_start    (w_start),
        .w_end      (w_end),
        .w_cplx     (w_cplx),
        .w_taken    (w_taken)
    );

    assign pos_a[0] = ptr;

    // One scanner per slot, chained: each starts after the previous end byte.
    for (genvar k = 0; k < SLOTS; k++) begin : g_scan
        steer_scan #(.WIN_B(WIN_B)) u_scan (
            .pos      (pos_a[k]),
            .w_start  (w_start),
            .w_end    (w_end),
            .w_cplx   (w_cplx),
            .w_taken  (w_taken),
            .found    (found_a[k]),
            .end_pos  (end_a[k]),
            .opc_pos  (opc_a[k]),
            .opc_len  (olen_a[k]),
            .is_cplx  (cplx_a[k]),
            .is_taken (taken_a[k])
        );
        if (k + 1 < SLOTS) begin : g_link
            assign pos_a[k+1] = end_a[k] + PW'(1);
        end
        assign slot_off[k*OW +: OW] = pos_a[k][OW-1:0];
        if (k == 0) begin : g_full
            steer_extract #(.WIN_B(WIN_B), .NB(FULL_MAX)) u_ext (
                .w_bytes   (w_bytes),
                .opc_pos   (opc_a[k]),
                .opc_len   (olen_a[k]),
                .out_bytes (full_bytes)
            );
        end else begin : g_part
            steer_extract #(.WIN_B(WIN_B), .NB(PART_MAX)) u_ext (
                .w_bytes   (w_bytes),
                .opc_pos   (opc_a[k]),
                .opc_len   (olen_a[k]),
                .out_bytes (part_bytes[(k-1)*PART_MAX*8 +: PART_MAX*8])
            );
        end
    end

    // Slot acceptance in program order; the last accepted slot sets the next position.
    always_comb begin
        acc     = '0;
        acc[0]  = found_a[0];
        for (int k = 1; k < SLOTS; k++) begin
            acc[k] = acc[k-1] && !taken_a[k-1] && found_a[k] && !cplx_a[k]
                     && (olen_a[k] <= PW'(PART_MAX));
        end
        new_ptr = ptr;
        l_taken = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            if (acc[k]) begin
                new_ptr = end_a[k] + PW'(1);
                l_taken = taken_a[k];
            end
        end
    end

    // Window exhaustion: any whole instruction left past the new position.
    assign more       = |(w_end >> new_ptr);
    assign done       = !acc[0] || l_taken || !more;
    assign win_req    = !active || done;
    assign slot_valid = acc & {SLOTS{active}};
endmodule

// File: rtl/insn_steer_chk.sv
// Property checker for the steering unit, attached by bind.
// Assumes: the top runs with the package default sizes.
module insn_steer_chk #(
    parameter int SLOTS = steer_pkg::SLOTS,
    localparam int OW = $clog2(steer_pkg::WIN_B)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                line_load,
    input logic [SLOTS-1:0]    slot_valid,
    input logic [SLOTS*OW-1:0] slot_off,
    input logic                win_req
);
    logic [OW-1:0] off0;
    assign off0 = slot_off[OW-1:0];

    // R4: slots fill in program order with rising offsets.
    for (genvar k = 1; k < SLOTS; k++) begin : g_ord
        p_in_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[k] |-> (slot_valid[k-1] &&
                (slot_off[k*OW +: OW] > slot_off[(k-1)*OW +: OW])));
    end

    // R8: a busy window always dispatches something.
    p_busy_dispatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_req |-> slot_valid[0]);

    // R10: a window that stays busy moves forward.
    p_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid[0] && !win_req) |=> (slot_valid[0] && (off0 > $past(off0))));

    // R2: a freshly loaded window dispatches from offset 0.
    p_entry_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_load && win_req) |=> (!slot_valid[0] || (off0 == '0)));

    // R9: a load offered while busy does not restart the window.
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_load && !win_req && slot_valid[0]) |=> (off0 != '0));
endmodule

bind insn_steer insn_steer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_load  (line_load),
    .slot_valid (slot_valid),
    .slot_off   (slot_off),
    .win_req    (win_req)
);

// File: tb/insn_steer_test.sv
// Bench: generated lines over all entry offsets and several length mixes,
// checked every cycle against an arithmetic model of the requirements.
module insn_steer_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_load = 1'b0;
    logic [4:0]   line_entry = '0;
    logic [255:0] line_bytes = '0;
    logic [31:0]  line_start = '0, line_end = '0, line_cplx = '0, line_taken = '0;
    logic [2:0]   slot_valid;
    logic [11:0]  slot_off;
    logic [87:0]  full_bytes;
    logic [127:0] part_bytes;
    logic         win_req;

    int n_cmp = 0;
    int n_bad = 0;
    int unsigned rs = 32'h1234_5678;

    logic [7:0] m_b[16];
    bit m_s[16], m_e[16], m_c[16], m_t[16];
    bit m_act = 0;
    int m_ptr = 0;
    bit e_v[3];
    int e_off[3], e_o[3], e_end[3];
    bit e_req, e_done;
    int e_np;

    insn_steer uut (
        .clk(clk), .rst_n(rst_n), .line_load(line_load), .line_entry(line_entry),
        .line_bytes(line_bytes), .line_start(line_start), .line_end(line_end),
        .line_cplx(line_cplx), .line_taken(line_taken), .slot_valid(slot_valid),
        .slot_off(slot_off), .full_bytes(full_bytes), .part_bytes(part_bytes),
        .win_req(win_req)
    );

    always #4 clk = ~clk;

    function int unsigned rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Build a line of instructions; mode picks the length/flag mix.
    task automatic gen_line(int mode);
        int pos, n, pc, ol, s, e;
        int starts[32];
        pos = 0; n = 0;
        line_start = '0; line_end = '0; line_cplx = '0; line_taken = '0;
        for (int b = 0; b < 32; b++) line_bytes[b*8 +: 8] = 8'(rnd());
        while (pos < 32) begin
            case (mode)
                1:       begin pc = 0; ol = 1; end
                2:       begin pc = int'(rnd() % 2); ol = 1 + int'(rnd() % 4); end
                3:       begin pc = int'(rnd() % 2); ol = 8 + int'(rnd() % 2); end
                default: begin pc = int'(rnd() % 3); ol = 1 + int'(rnd() % 11); end
            endcase
            starts[n] = pos; n++;
            s = pos + pc; e = pos + pc + ol - 1;
            if (s < 32) begin
                line_start[s] = 1'b1;
                line_cplx[s]  = (mode == 2) ? 1'b1 : (rnd() % 4 == 0);
            end
            if (e < 32) begin
                line_end[e]   = 1'b1;
                line_taken[e] = (rnd() % 10 == 0);
            end
            pos = pos + pc + ol;
        end
        line_entry = 5'(starts[int'(rnd() % n)]);
    endtask

    // Expected outputs from the model window state.
    task automatic model_eval();
        int p, last, fe, fo;
        bit stop, lt, more, ok;
        p = m_ptr; last = -1; stop = 0; lt = 0; more = 0;
        for (int k = 0; k < 3; k++) begin e_v[k] = 0; e_off[k] = 0; e_o[k] = 0; e_end[k] = 0; end
        for (int k = 0; k < 3; k++) begin
            if (!stop) begin
                fe = -1;
                for (int j = p; j < 16; j++) if (fe < 0 && m_e[j]) fe = j;
                fo = -1;
                for (int j = p; j <= fe; j++) if (fo < 0 && m_s[j]) fo = j;
                if (fo < 0) fo = p;
                ok = (fe >= 0);
                if (ok && k > 0) ok = !lt && !m_c[fo] && (fe - fo + 1 <= 8);
                if (ok) begin
                    e_v[k] = m_act; e_off[k] = p; e_o[k] = fo; e_end[k] = fe;
                    lt = m_t[fe]; last = k; p = fe + 1;
                end else begin
                    stop = 1;
                end
            end
        end
        for (int j = p; j < 16; j++) if (m_e[j]) more = 1;
        e_done = (last < 0) || lt || !more;
        e_req  = !m_act || e_done;
        e_np   = p;
    endtask

    // Model state update for the inputs driven this cycle.
    task automatic model_step();
        int src;
        if (line_load && e_req) begin
            for (int j = 0; j < 16; j++) begin
                src = int'(line_entry) + j;
                if (src < 32) begin
                    m_b[j] = line_bytes[src*8 +: 8];
                    m_s[j] = line_start[src]; m_e[j] = line_end[src];
                    m_c[j] = line_cplx[src];  m_t[j] = line_taken[src];
                end else begin
                    m_b[j] = 8'h00; m_s[j] = 0; m_e[j] = 0; m_c[j] = 0; m_t[j] = 0;
                end
            end
            m_act = 1; m_ptr = 0;
        end else if (m_act) begin
            if (e_done) m_act = 0;
            else m_ptr = e_np;
        end
    endtask

    task automatic compare_all();
        logic [127:0] exp_b, act_b;
        int nb;
        model_eval();
        chk("R8 R9 win_req", 128'(win_req), 128'(e_req));
        for (int k = 0; k < 3; k++) begin
            chk("R4 R5 R6 R7 slot valid", 128'(slot_valid[k]), 128'(e_v[k]));
            if (e_v[k]) begin
                chk("R2 R10 slot offset", 128'(slot_off[k*4 +: 4]), 128'(e_off[k]));
                nb = (k == 0) ? 11 : 8;
                exp_b = '0;
                for (int b = 0; b < nb; b++)
                    if (e_o[k] + b <= e_end[k]) exp_b[b*8 +: 8] = m_b[e_o[k] + b];
                act_b = (k == 0) ? 128'(full_bytes) : 128'(part_bytes[(k-1)*64 +: 64]);
                chk("R3 slot bytes", act_b, exp_b);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int mode;
        repeat (3) @(negedge clk);
        // R1: idle while reset is held.
        chk("R1 reset valid", 128'(slot_valid), 128'(0));
        chk("R1 reset win_req", 128'(win_req), 128'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 128'(slot_valid), 128'(0));
        for (int cyc = 0; cyc < 24000; cyc++) begin
            compare_all();
            mode = (cyc / 6000) % 4;
            if (e_req) begin
                gen_line(mode);
                line_load = 1'b1;
            end else if (rnd() % 3 == 0) begin
                gen_line(0);          // R9: offered while busy, must be ignored
                line_load = 1'b1;
            end else begin
                line_load = 1'b0;
            end
            model_step();
            @(negedge clk);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule